// File: doc/BRIEF.md
# Test Output Selector with Bypass Dividers

This block drives two outputs of a clock synthesizer: the main clock output and a single diagnostic test pin. A 3-bit test-select code chooses what appears on the test pin. The choices are the serial configuration register's shift output, the constants one and zero, the reference clock divided by sixteen, the M feedback counter's terminal pulse, the main clock, and the main clock divided by four. One code value also switches the divider chain into a bypass path. In that path the serial interface clock replaces the synthesized clock as the source of both the M counter and the N post-divider. The N divider then drives the main output and the M counter drives the test pin. This lets a board run slow functional tests with a clock it controls directly.

The block runs on one fast sampling clock. The serial clock, reference clock and synthesized clock arrive as levels. Each is edge-detected on the sampling clock, and every divider advances on the detected rising edges. A change of the N code, the M value or the clock source clears the dividers, so the new ratio is in force from the first output period after the change.

Top module: `testsel_top`

## Requirements
- R1: While rst_n is low at a rising clk edge, both fout_o and test_o are low after that edge, whatever the other inputs are.
- R2: Test code 3'b001 drives test_o to a steady 1, and test code 3'b101 drives it to a steady 0.
- R3: Test code 3'b000 copies sr_out_i to test_o with one clk cycle of delay.
- R4: Test code 3'b010 puts the reference clock divided by 16 on test_o, with a duty cycle of exactly 50%.
- R5: Test code 3'b011 puts the M counter output on test_o. For M of 2 or more, this output is high for one source clock period out of every M periods. For M of 0 or 1, it stays high.
- R6: Test code 3'b100 puts the main output clock on test_o, and test code 3'b111 puts that clock divided by 4 on test_o.
- R7: The N code sets the ratio from the source clock to fout_o: 2'b00 divides by 2, 2'b01 by 4 and 2'b10 by 8, each with 50% duty. 2'b11 gives a ratio of 1, with fout_o following the source level one clk cycle later.
- R8: Test code 3'b110 selects bypass. The serial clock sclk_i replaces synclk_i as the source of both the N divider and the M counter, and test_o carries the M counter output.
- R9: A change of N code, M value or clock source restarts the dividers. The first rising edge of an output follows within one new output period, and every period after the change has the new length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all registers |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial interface clock level, used as the source in bypass |
| refclk_i | input | 1 | Reference clock level |
| synclk_i | input | 1 | Synthesized clock level, the normal divider source |
| m_val_i | input | MW | M counter modulus |
| n_code_i | input | 2 | Post-divider ratio code |
| t_code_i | input | 3 | Test-select code |
| sr_out_i | input | 1 | Serial output of the configuration shift register |
| fout_o | output | 1 | Main clock output |
| test_o | output | 1 | Diagnostic test pin |

## Verification
The bench builds the block with MW = 4, so the M counter can be swept over every modulus from 0 to 15. In bypass this sweep is combined with all four N codes. The three source clocks are given half-periods of 3, 2 and 1 sampling cycles. Each selection therefore produces a distinct period and high time, and the bench derives these by arithmetic and measures them over several complete periods. The narrow M width also keeps the wrap, clamp and restart cases short enough to observe right after a mid-period change of N or M.

// File: rtl/tsel_pkg.sv
// Shared definitions for the test output selector.
// Assumes: the N code is 2 bits wide and the largest even ratio is 8.
package tsel_pkg;

    // Test-select codes. The values are fixed because a serial stream decodes them.
    typedef enum logic [2:0] {
        TS_SHIFT  = 3'b000,
        TS_ONE    = 3'b001,
        TS_REF16  = 3'b010,
        TS_MCNT   = 3'b011,
        TS_FOUT   = 3'b100,
        TS_ZERO   = 3'b101,
        TS_BYPASS = 3'b110,
        TS_FOUT4  = 3'b111
    } tsel_e;

    localparam int NCODE_W = 2;
    localparam int HALF_W  = 2;

    // Last count value of the half-period counter for an N code.
    function automatic logic [HALF_W-1:0] half_last(input logic [NCODE_W-1:0] code);
        case (code)
            2'b00:   return HALF_W'(0);
            2'b01:   return HALF_W'(1);
            2'b10:   return HALF_W'(3);
            default: return HALF_W'(0);
        endcase
    endfunction

    // The ratio-1 code passes the source straight through.
    function automatic logic is_passthru(input logic [NCODE_W-1:0] code);
        return code == 2'b11;
    endfunction

endpackage

// File: rtl/tsel_edge.sv
// Rising-edge detector for a slow clock that arrives as a level.
// Assumes: the level stays high and low for at least one clk cycle each.
module tsel_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o
);
    logic prev_q;

    // Keep the previous sampled level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/tsel_pow2div.sv
// Fixed power-of-two divider: counts rising edges and outputs the count MSB.
// Assumes: rise_i is a one-cycle pulse per source edge. clr_i restarts at zero.
module tsel_pow2div #(
    parameter int W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic rise_i,
    output logic out_o
);
    logic [W-1:0] cnt_q;

    // Count source rising edges, restarting on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr_i)  cnt_q <= '0;
        else if (rise_i) cnt_q <= cnt_q + W'(1);
    end

    assign out_o = cnt_q[W-1];
endmodule

// File: rtl/tsel_postdiv.sv
// N post-divider. Even ratios toggle the output every ratio/2 source rises,
// which gives a 50% duty cycle. Ratio 1 registers the source level.
// Assumes: code_i follows the N code table in tsel_pkg.
module tsel_postdiv
    import tsel_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic [NCODE_W-1:0] code_i,
    input  logic               lvl_i,
    input  logic               rise_i,
    output logic               out_o
);
    logic [HALF_W-1:0] cnt_q;
    logic              out_q;
    logic [HALF_W-1:0] lim;

    assign lim = half_last(code_i);

    // Half-period counting, pass-through, and restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            out_q <= 1'b0;
        end else if (clr_i) begin
            cnt_q <= '0;
            out_q <= 1'b0;
        end else if (is_passthru(code_i)) begin
            cnt_q <= '0;
            out_q <= lvl_i;
        end else if (rise_i) begin
            if (cnt_q == lim) begin
                cnt_q <= '0;
                out_q <= ~out_q;
            end else begin
                cnt_q <= cnt_q + HALF_W'(1);
            end
        end
    end

    assign out_o = out_q;
endmodule

// File: rtl/tsel_modcnt.sv
// Modulo-M counter. The output is high while the count sits on its last value,
// which is one source period in every M. M of 0 or 1 holds the output high.
// Assumes: rise_i is a one-cycle pulse per source edge.
module tsel_modcnt #(
    parameter int MW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic [MW-1:0] m_i,
    input  logic          rise_i,
    output logic          tc_o
);
    logic [MW-1:0] cnt_q;
    logic [MW-1:0] last;

    assign last = (m_i < MW'(2)) ? '0 : m_i - MW'(1);

    // Wrap at the last value. This also recovers when M shrinks below the count.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr_i)  cnt_q <= '0;
        else if (rise_i) cnt_q <= (cnt_q >= last) ? '0 : cnt_q + MW'(1);
    end

    assign tc_o = (cnt_q == last);
endmodule

// File: rtl/testsel_top.sv
// Test output selector with bypass dividers.
// Samples three slow clocks as levels on clk and drives fout_o from the N
// post-divider. test_o takes one of eight sources chosen by t_code_i. The
// bypass code moves the divider source from synclk_i to sclk_i.
// Assumes: every sampled clock half-period lasts at least one clk cycle.
module testsel_top
    import tsel_pkg::*;
#(
    parameter int MW = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_i,
    input  logic               refclk_i,
    input  logic               synclk_i,
    input  logic [MW-1:0]      m_val_i,
    input  logic [NCODE_W-1:0] n_code_i,
    input  logic [2:0]         t_code_i,
    input  logic               sr_out_i,
    output logic               fout_o,
    output logic               test_o
);
    localparam int NSRC    = 3;
    localparam int SRC_SER = 0;
    localparam int SRC_SYN = 1;
    localparam int SRC_REF = 2;

    logic [NSRC-1:0] lvl_vec;
    logic [NSRC-1:0] rise_vec;
    logic            bypass;
    logic            src_lvl;
    logic            src_rise;
    logic [NCODE_W-1:0] n_q;
    logic [MW-1:0]   m_q;
    logic            byp_q;
    logic            resync;
    logic            m_resync;
    logic            fout_int;
    logic            fout_rise;
    logic            fdiv4;
    logic            ref16;
    logic            mtc;
    logic            test_d;
    logic            test_q;

    assign lvl_vec = {refclk_i, synclk_i, sclk_i};

    for (genvar g = 0; g < NSRC; g++) begin : g_edge
        tsel_edge u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl_i  (lvl_vec[g]),
            .rise_o (rise_vec[g])
        );
    end

    assign bypass   = (t_code_i == TS_BYPASS);
    assign src_lvl  = bypass ? lvl_vec[SRC_SER]  : lvl_vec[SRC_SYN];
    assign src_rise = bypass ? rise_vec[SRC_SER] : rise_vec[SRC_SYN];

    // Hold the last settings so that a change can be detected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q   <= '0;
            m_q   <= '0;
            byp_q <= 1'b0;
        end else begin
            n_q   <= n_code_i;
            m_q   <= m_val_i;
            byp_q <= bypass;
        end
    end

    assign resync   = (n_code_i != n_q) || (bypass != byp_q);
    assign m_resync = resync || (m_val_i != m_q);

    tsel_postdiv u_ndiv (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (resync),
        .code_i (n_code_i),
        .lvl_i  (src_lvl),
        .rise_i (src_rise),
        .out_o  (fout_int)
    );

    tsel_modcnt #(.MW(MW)) u_mcnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (m_resync),
        .m_i    (m_val_i),
        .rise_i (src_rise),
        .tc_o   (mtc)
    );

    tsel_edge u_fedge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (fout_int),
        .rise_o (fout_rise)
    );

    tsel_pow2div #(.W(2)) u_fdiv4 (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (resync),
        .rise_i (fout_rise),
        .out_o  (fdiv4)
    );

    tsel_pow2div #(.W(4)) u_ref16 (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (1'b0),
        .rise_i (rise_vec[SRC_REF]),
        .out_o  (ref16)
    );

    // Pick the test pin source from the select code.
    always_comb begin
        case (tsel_e'(t_code_i))
            TS_SHIFT:  test_d = sr_out_i;
            TS_ONE:    test_d = 1'b1;
            TS_REF16:  test_d = ref16;
            TS_MCNT:   test_d = mtc;
            TS_FOUT:   test_d = fout_int;
            TS_ZERO:   test_d = 1'b0;
            TS_BYPASS: test_d = mtc;
            TS_FOUT4:  test_d = fdiv4;
            default:   test_d = 1'b0;
        endcase
    end

    // Register the test pin.
    always_ff @(posedge clk) begin
        if (!rst_n) test_q <= 1'b0;
        else        test_q <= test_d;
    end

    assign fout_o = fout_int;
    assign test_o = test_q;
endmodule

// File: rtl/tsel_checker.sv
// Assertions for testsel_top, attached with bind.
module tsel_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sclk_i,
    input logic [1:0] n_code_i,
    input logic [2:0] t_code_i,
    input logic       sr_out_i,
    input logic       fout_o,
    input logic       test_o
);
    AST_RST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!fout_o && !test_o)); // R1

    AST_TEST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(t_code_i) == 3'b001) |-> test_o); // R2

    AST_TEST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(t_code_i) == 3'b101) |-> !test_o); // R2

    AST_SHIFT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(t_code_i) == 3'b000) |-> (test_o == $past(sr_out_i))); // R3

    AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) &&
         $past(t_code_i) == 3'b110 && $past(t_code_i, 2) == 3'b110 &&
         $past(n_code_i) == 2'b11 && $past(n_code_i, 2) == 2'b11)
        |-> (fout_o == $past(sclk_i))); // R7
endmodule

bind testsel_top tsel_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_i   (sclk_i),
    .n_code_i (n_code_i),
    .t_code_i (t_code_i),
    .sr_out_i (sr_out_i),
    .fout_o   (fout_o),
    .test_o   (test_o)
);

// File: tb/sim_testsel_top.sv
module sim_testsel_top;
    localparam int MW     = 4;
    localparam int S_HALF = 3;
    localparam int Y_HALF = 2;
    localparam int R_HALF = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk_i = 1'b0, synclk_i = 1'b0, refclk_i = 1'b0;
    logic [MW-1:0] m_val_i = '0;
    logic [1:0] n_code_i = 2'b00;
    logic [2:0] t_code_i = 3'b000;
    logic [7:0] lfsr = 8'h5A;
    logic sr_out_i;
    logic fout_o, test_o;
    int sc = 0, yc = 0, rc = 0;
    int checks = 0, errors = 0;
    int rcnt[2], pmin[2], pmax[2], hmin[2], hmax[2], ones[2], first[2];

    assign sr_out_i = lfsr[0];

    always #2 clk = ~clk;

    testsel_top #(.MW(MW)) u0 (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .refclk_i(refclk_i),
        .synclk_i(synclk_i), .m_val_i(m_val_i), .n_code_i(n_code_i),
        .t_code_i(t_code_i), .sr_out_i(sr_out_i), .fout_o(fout_o), .test_o(test_o)
    );

    // Slow source clocks and serial data, all driven away from the active edge.
    always @(negedge clk) begin
        if (sc == S_HALF - 1) begin sc <= 0; sclk_i <= ~sclk_i; end else sc <= sc + 1;
        if (yc == Y_HALF - 1) begin yc <= 0; synclk_i <= ~synclk_i; end else yc <= yc + 1;
        if (rc == R_HALF - 1) begin rc <= 0; refclk_i <= ~refclk_i; end else rc <= rc + 1;
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int ratio(input int code);
        return (code == 0) ? 2 : (code == 1) ? 4 : (code == 2) ? 8 : 1;
    endfunction

    task automatic cfg(input logic [2:0] t, input int n, input int m);
        @(negedge clk);
        t_code_i = t;
        n_code_i = 2'(n);
        m_val_i  = MW'(m);
    endtask

    // Record rises, periods, high times and ones on index 0 (fout_o) and 1 (test_o).
    task automatic measure(input int ncyc);
        logic prev[2], cur[2];
        int lr[2], rs[2];
        for (int k = 0; k < 2; k++) begin
            rcnt[k] = 0; pmin[k] = 1000000; pmax[k] = 0; hmin[k] = 1000000;
            hmax[k] = 0; ones[k] = 0; first[k] = -1; lr[k] = -1; rs[k] = -1;
        end
        @(posedge clk); #1;
        prev[0] = fout_o; prev[1] = test_o;
        for (int i = 1; i <= ncyc; i++) begin
            @(posedge clk); #1;
            cur[0] = fout_o; cur[1] = test_o;
            for (int k = 0; k < 2; k++) begin
                if (cur[k]) ones[k]++;
                if (cur[k] && !prev[k]) begin
                    rcnt[k]++;
                    if (first[k] < 0) first[k] = i;
                    if (lr[k] >= 0) begin
                        if (i - lr[k] < pmin[k]) pmin[k] = i - lr[k];
                        if (i - lr[k] > pmax[k]) pmax[k] = i - lr[k];
                    end
                    lr[k] = i; rs[k] = i;
                end else if (!cur[k] && prev[k] && rs[k] >= 0) begin
                    if (i - rs[k] < hmin[k]) hmin[k] = i - rs[k];
                    if (i - rs[k] > hmax[k]) hmax[k] = i - rs[k];
                end
                prev[k] = cur[k];
            end
        end
    endtask

    task automatic chk_wave(input string tag, input int k, input int per, input int hi);
        chk({tag, " period min"}, pmin[k], per);
        chk({tag, " period max"}, pmax[k], per);
        chk({tag, " high min"}, hmin[k], hi);
        chk({tag, " high max"}, hmax[k], hi);
    endtask

    task automatic settle_measure(input int per);
        repeat (per + 12) @(posedge clk);
        measure(3 * per + 20);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int mism;
        // R1: reset holds both outputs low even with the constant-one code selected.
        t_code_i = 3'b001;
        repeat (6) @(posedge clk);
        #1;
        chk("R1 fout in reset", int'(fout_o), 0);
        chk("R1 test in reset", int'(test_o), 0);
        @(negedge clk); rst_n = 1'b1;

        // R2: constants
        cfg(3'b001, 0, 3); repeat (4) @(posedge clk); measure(60);
        chk("R2 const one", ones[1], 60);
        cfg(3'b101, 0, 3); repeat (4) @(posedge clk); measure(60);
        chk("R2 const zero", ones[1], 0);

        // R3: shift output follows with one cycle of delay
        cfg(3'b000, 0, 3); repeat (3) @(posedge clk);
        mism = 0;
        for (int i = 0; i < 200; i++) begin
            @(posedge clk); #1;
            if (test_o !== sr_out_i) mism++;
        end
        chk("R3 shift follow mismatches", mism, 0);

        // R4: reference divided by 16
        cfg(3'b010, 0, 3); settle_measure(32 * R_HALF);
        chk_wave("R4 ref16", 1, 32 * R_HALF, 16 * R_HALF);

        // R6, R7: normal source, every N code, fout on the pin and fout divided by 4
        for (int n = 0; n < 4; n++) begin
            cfg(3'b100, n, 3); settle_measure(2 * ratio(n) * Y_HALF);
            chk_wave("R7 fout", 0, 2 * ratio(n) * Y_HALF, ratio(n) * Y_HALF);
            chk_wave("R6 test=fout", 1, 2 * ratio(n) * Y_HALF, ratio(n) * Y_HALF);
            cfg(3'b111, n, 3); settle_measure(8 * ratio(n) * Y_HALF);
            chk_wave("R6 test=fout/4", 1, 8 * ratio(n) * Y_HALF, 4 * ratio(n) * Y_HALF);
        end

        // R5: M counter on the normal source
        for (int m = 0; m < 16; m++) begin
            cfg(3'b011, 0, m);
            if (m < 2) begin
                settle_measure(4 * Y_HALF);
                chk("R5 M<2 held high", ones[1], 3 * 4 * Y_HALF + 20);
            end else begin
                settle_measure(2 * m * Y_HALF);
                chk_wave("R5 mcnt", 1, 2 * m * Y_HALF, 2 * Y_HALF);
            end
        end

        // R8: bypass, every N code and every M value
        for (int n = 0; n < 4; n++) begin
            for (int m = 0; m < 16; m++) begin
                int per;
                per = (m < 2) ? 2 * ratio(n) * S_HALF : 2 * m * S_HALF;
                if (2 * ratio(n) * S_HALF > per) per = 2 * ratio(n) * S_HALF;
                cfg(3'b110, n, m); settle_measure(per);
                chk_wave("R8 bypass fout", 0, 2 * ratio(n) * S_HALF, ratio(n) * S_HALF);
                if (m < 2) chk("R8 bypass M<2 high", ones[1], 3 * per + 20);
                else chk_wave("R8 bypass mcnt", 1, 2 * m * S_HALF, 2 * S_HALF);
            end
        end

        // R9: restart after changing N and then M in mid period
        cfg(3'b110, 0, 5); repeat (101) @(posedge clk);
        cfg(3'b110, 2, 5); measure(130);
        chk("R9 first fout rise in time", int'(first[0] > 0 && first[0] <= 16 * S_HALF + 8), 1);
        chk("R9 fout period after change", pmin[0], 16 * S_HALF);
        chk("R9 fout period after change max", pmax[0], 16 * S_HALF);
        repeat (7) @(posedge clk);
        cfg(3'b110, 2, 3); measure(60);
        chk("R9 first mcnt rise in time", int'(first[1] > 0 && first[1] <= 6 * S_HALF + 8), 1);
        chk("R9 mcnt period after change", pmin[1], 6 * S_HALF);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule